// File: doc/BRIEF.md
# CAN Message Buffer Selection Unit

This block holds eight message slots for a CAN controller. Each slot has an identifier word, a length-code word, four data words and an acceptance mask. The block decides which slot the protocol engine sends next, and which slot stores each frame the engine receives. Lower slot numbers always win. This holds for pending transmit requests and for receive-filter hits.

A CPU configures the slots through a word-wide register port with a ready handshake. It sets per-slot enable and transmit-request bits, and it releases stored frames with write-one-to-clear flags. A disabled slot takes no part in selection, so its words act as plain RAM. A slot still holding an unreleased frame is passed over by the filter. Several slots given the same filter therefore fill one after another as a small receive queue. When no slot can take a frame, the frame is dropped and a one-cycle lost pulse is raised.

Top module: `can_mbuf_sel`

## Requirements
- R1: Register map, word addresses. Address bit 6 = 0 selects slot `addr[5:3]`, with word `addr[2:0]` meaning: 0 identifier (11 bits), 1 length code (4 bits), 2..5 data words k = 0..3 (word k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8), 6 acceptance mask, 7 reads 0. Address 64 holds the enable bits, 65 the transmit requests, 66 the receive-full flags and 67 the transmit-complete flags, with bit n belonging to slot n. Unused bits read 0.
- R2: When the scheduler is idle and some slot is both enabled and requesting, it loads the lowest-numbered such slot. It drives that slot's identifier, length code and data on the transmit outputs, and asserts `tx_valid`, two clock edges after the request becomes visible.
- R3: The selected slot stays on the transmit outputs until `tx_done` is seen, even if a lower-numbered request appears meanwhile. `tx_done` clears that slot's request bit and sets its transmit-complete flag. Selection is then made afresh.
- R4: A received identifier matches a slot when, at every bit position where the slot's mask is 1, it equals the slot's stored identifier. Positions with mask 0 are ignored.
- R5: An arriving frame is stored only in the lowest-numbered matching slot whose receive-full flag is clear. Full slots are skipped.
- R6: A slot with enable 0 is never selected for transmit and never stores a received frame. Its words remain readable and writable.
- R7: A CPU write with byte enables 11 writes the whole word. With 01 it writes the low byte and forces the high byte to 0. With 10 or 00 nothing changes.
- R8: A stored frame writes the identifier, the data and the length code, clamped to 8 if above 8, at one clock edge. The same edge sets the slot's receive-full flag. Writing 1 to a flag bit clears it.
- R9: A frame with no enabled, non-full matching slot is discarded. `rx_lost` is high for exactly the cycle after `rx_valid`.
- R10: `cpu_ready` is low in any cycle where `rx_valid` is high or a transmit slot is being loaded. A waiting request is granted after at most 63 stalled cycles.
- R11: After reset all registers and flags are 0, `tx_valid` is 0 and `cpu_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until granted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 7 | Word address |
| cpu_be | input | 2 | Byte enables (bit 0 low byte) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed word |
| cpu_ready | output | 1 | Access is taken at a clock edge where request and ready are both high |
| rx_valid | input | 1 | Received frame present this cycle |
| rx_id | input | 11 | Received identifier |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data, byte n in bits 8n+7:8n |
| rx_lost | output | 1 | Frame discarded pulse |
| rx_full | output | 8 | Receive-full flags per slot |
| tx_valid | output | 1 | A selected frame is on the transmit outputs |
| tx_slot | output | 3 | Index of the selected slot |
| tx_id | output | 11 | Identifier of the selected frame |
| tx_dlc | output | 4 | Length code of the selected frame |
| tx_data | output | 64 | Data of the selected frame |
| tx_done | input | 1 | Engine reports the selected frame was sent |
| tx_cmp | output | 8 | Transmit-complete flags per slot |

## Verification
The bench sends a series of frames against overlapping filters. An exact and a ranged filter share one identifier, a filter pair forms a queue, and an accept-all slot sits behind them. A design that picks the highest match, or ignores full flags, stores into the wrong slot or overwrites an unreleased frame. A frame aimed only at a disabled slot must be lost, and a length code of 12 must read back as 8. A lower-numbered request raised mid-transmission must not preempt the current slot but must go next. Byte-enable patterns on a disabled slot show whether a high-byte write leaks in. A request held against a long receive burst shows whether the stall ends at its bound or hangs.

// File: rtl/can_mbuf_pkg.sv
package can_mbuf_pkg;

   localparam int unsigned OFF_W = 3;

   typedef enum logic [2:0] {
      O_ID   = 3'd0,
      O_DLC  = 3'd1,
      O_D0   = 3'd2,
      O_D1   = 3'd3,
      O_D2   = 3'd4,
      O_D3   = 3'd5,
      O_MASK = 3'd6,
      O_RSVD = 3'd7
   } slot_off_e;

   typedef enum logic [1:0] {
      G_ENABLE = 2'd0,
      G_TXREQ  = 2'd1,
      G_RXFULL = 2'd2,
      G_TXCMP  = 2'd3
   } glob_reg_e;

   // low byte alone forces the high byte to zero
   function automatic logic [15:0] merge_word(input logic [1:0] be, input logic [15:0] wd);
      return be[1] ? wd : {8'h00, wd[7:0]};
   endfunction

endpackage

// File: rtl/mbuf_prio_pick.sv
module mbuf_prio_pick #(
   parameter int unsigned N     = 8,
   parameter int unsigned STYLE = 0,
   localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);

   assign any = |req;

   if (STYLE > 1) begin : g_bad_style
      $error("mbuf_prio_pick: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_chain
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end else begin : g_isolate
      logic [N-1:0] low_bit;
      assign low_bit = req & (~req + N'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (low_bit[i]) idx = idx | IW'(i);
         end
      end
   end

endmodule

// File: rtl/mbuf_rx_filter.sv
module mbuf_rx_filter #(
   parameter int unsigned NSLOT = 8,
   parameter int unsigned ID_W  = 11
) (
   input  logic [ID_W-1:0]  rx_id,
   input  logic [ID_W-1:0]  id_tab   [NSLOT],
   input  logic [ID_W-1:0]  mask_tab [NSLOT],
   input  logic [NSLOT-1:0] enable,
   input  logic [NSLOT-1:0] full,
   output logic [NSLOT-1:0] cand
);

   for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
      logic hit;
      assign hit     = ((rx_id ^ id_tab[s]) & mask_tab[s]) == '0;
      assign cand[s] = hit & enable[s] & ~full[s];
   end

endmodule

// File: rtl/mbuf_tx_sched.sv
module mbuf_tx_sched #(
   parameter int unsigned NSLOT      = 8,
   parameter int unsigned PICK_STYLE = 0,
   localparam int unsigned SLOT_AW   = $clog2(NSLOT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSLOT-1:0]   elig,
   input  logic               tx_done,
   output logic               load,
   output logic [SLOT_AW-1:0] pick,
   output logic               busy_q,
   output logic [SLOT_AW-1:0] slot_q
);

   logic any_elig;

   mbuf_prio_pick #(.N(NSLOT), .STYLE(PICK_STYLE)) u_pick (
      .req (elig),
      .idx (pick),
      .any (any_elig)
   );

   assign load = ~busy_q & any_elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         slot_q <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         slot_q <= pick;
      end else if (busy_q && tx_done) begin
         busy_q <= 1'b0;
      end
   end

   assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tx_done) |=> (busy_q && $stable(slot_q)))
      else $error("selected transmit slot changed before completion");

endmodule

// File: rtl/can_mbuf_sel.sv
module can_mbuf_sel
   import can_mbuf_pkg::*;
#(
   parameter int unsigned NSLOT      = 8,
   parameter int unsigned ID_W       = 11,
   parameter int unsigned DLC_W      = 4,
   parameter int unsigned DATA_BYTES = 8,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned STALL_MAX  = 64,
   parameter int unsigned PICK_STYLE = 0,
   localparam int unsigned SLOT_AW   = $clog2(NSLOT),
   localparam int unsigned ADDR_W    = SLOT_AW + OFF_W + 1,
   localparam int unsigned DATA_W    = DATA_BYTES * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [1:0]         cpu_be,
   input  logic [WORD_W-1:0]  cpu_wdata,
   output logic [WORD_W-1:0]  cpu_rdata,
   output logic               cpu_ready,
   input  logic               rx_valid,
   input  logic [ID_W-1:0]    rx_id,
   input  logic [DLC_W-1:0]   rx_dlc,
   input  logic [DATA_W-1:0]  rx_data,
   output logic               rx_lost,
   output logic [NSLOT-1:0]   rx_full,
   output logic               tx_valid,
   output logic [SLOT_AW-1:0] tx_slot,
   output logic [ID_W-1:0]    tx_id,
   output logic [DLC_W-1:0]   tx_dlc,
   output logic [DATA_W-1:0]  tx_data,
   input  logic               tx_done,
   output logic [NSLOT-1:0]   tx_cmp
);

   localparam int unsigned NWORDS = DATA_BYTES / 2;
   localparam int unsigned CNT_W  = $clog2(STALL_MAX + 1);

   // elaboration-time parameter checks
   if (NSLOT < 2 || NSLOT > WORD_W) begin : g_bad_nslot
      $error("can_mbuf_sel: NSLOT must fit a control word");
   end
   if (ID_W > WORD_W) begin : g_bad_id
      $error("can_mbuf_sel: identifier wider than a CPU word");
   end
   if (WORD_W != 16) begin : g_bad_word
      $error("can_mbuf_sel: byte-enable rule assumes 16-bit words");
   end
   if ((DATA_BYTES % 2) != 0 || NWORDS > 4) begin : g_bad_data
      $error("can_mbuf_sel: DATA_BYTES must be even and at most 8");
   end
   if ((2 ** DLC_W) <= DATA_BYTES) begin : g_bad_dlc
      $error("can_mbuf_sel: DLC_W too narrow for DATA_BYTES");
   end
   if (STALL_MAX < 2) begin : g_bad_stall
      $error("can_mbuf_sel: STALL_MAX must be at least 2");
   end

   // slot storage views
   logic [ID_W-1:0]   id_tab   [NSLOT];
   logic [ID_W-1:0]   mask_tab [NSLOT];
   logic [DLC_W-1:0]  dlc_tab  [NSLOT];
   logic [DATA_W-1:0] dat_tab  [NSLOT];

   logic [NSLOT-1:0] en_q, txreq_q, rxfull_q, txcmp_q;
   logic [NSLOT-1:0] en_n, txreq_n, rxfull_n, txcmp_n;

   // CPU decode
   logic               a_glob;
   logic [SLOT_AW-1:0] a_slot;
   logic [OFF_W-1:0]   a_off;
   logic [OFF_W-1:0]   a_word;
   logic [1:0]         g_sel;
   logic               cpu_fire, cpu_wr;
   logic [WORD_W-1:0]  wmerged;

   assign a_glob  = cpu_addr[ADDR_W-1];
   assign a_slot  = cpu_addr[OFF_W +: SLOT_AW];
   assign a_off   = cpu_addr[OFF_W-1:0];
   assign a_word  = a_off - OFF_W'(O_D0);
   assign g_sel   = cpu_addr[1:0];
   assign cpu_fire = cpu_req & cpu_ready;
   assign cpu_wr   = cpu_fire & cpu_we & cpu_be[0];
   assign wmerged  = merge_word(cpu_be, cpu_wdata);

   // receive path
   logic [NSLOT-1:0]   rx_cand;
   logic [SLOT_AW-1:0] rx_idx;
   logic               rx_any, rx_store;
   logic [DLC_W-1:0]   dlc_clamp;
   logic               lost_q;

   mbuf_rx_filter #(.NSLOT(NSLOT), .ID_W(ID_W)) u_filter (
      .rx_id    (rx_id),
      .id_tab   (id_tab),
      .mask_tab (mask_tab),
      .enable   (en_q),
      .full     (rxfull_q),
      .cand     (rx_cand)
   );

   mbuf_prio_pick #(.N(NSLOT), .STYLE(PICK_STYLE)) u_rx_pick (
      .req (rx_cand),
      .idx (rx_idx),
      .any (rx_any)
   );

   assign rx_store  = rx_valid & rx_any;
   assign dlc_clamp = (rx_dlc > DLC_W'(DATA_BYTES)) ? DLC_W'(DATA_BYTES) : rx_dlc;

   // transmit path
   logic               tx_load, tx_busy;
   logic [SLOT_AW-1:0] tx_pick, tx_cur;
   logic [NSLOT-1:0]   tx_elig;
   logic [ID_W-1:0]    tx_id_q;
   logic [DLC_W-1:0]   tx_dlc_q;
   logic [DATA_W-1:0]  tx_dat_q;

   assign tx_elig = txreq_q & en_q;

   mbuf_tx_sched #(.NSLOT(NSLOT), .PICK_STYLE(PICK_STYLE)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (tx_elig),
      .tx_done (tx_done),
      .load    (tx_load),
      .pick    (tx_pick),
      .busy_q  (tx_busy),
      .slot_q  (tx_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_id_q  <= '0;
         tx_dlc_q <= '0;
         tx_dat_q <= '0;
      end else if (tx_load) begin
         tx_id_q  <= id_tab[tx_pick];
         tx_dlc_q <= dlc_tab[tx_pick];
         tx_dat_q <= dat_tab[tx_pick];
      end
   end

   // per-slot storage
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [ID_W-1:0]   id_r, msk_r;
      logic [DLC_W-1:0]  dlc_r;
      logic [DATA_W-1:0] dat_r;
      logic              hit_rx, hit_cpu;

      assign hit_rx  = rx_store && (rx_idx == SLOT_AW'(s));
      assign hit_cpu = cpu_wr && !a_glob && (a_slot == SLOT_AW'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_r  <= '0;
            msk_r <= '0;
            dlc_r <= '0;
            dat_r <= '0;
         end else begin
            if (hit_rx) begin
               id_r  <= rx_id;
               dlc_r <= dlc_clamp;
               dat_r <= rx_data;
            end
            if (hit_cpu) begin
               case (slot_off_e'(a_off))
                  O_ID:   id_r  <= wmerged[ID_W-1:0];
                  O_DLC:  dlc_r <= wmerged[DLC_W-1:0];
                  O_MASK: msk_r <= wmerged[ID_W-1:0];
                  O_RSVD: ;
                  default: begin
                     if (int'(a_word) < NWORDS)
                        dat_r[int'(a_word)*WORD_W +: WORD_W] <= wmerged;
                  end
               endcase
            end
         end
      end

      assign id_tab[s]   = id_r;
      assign mask_tab[s] = msk_r;
      assign dlc_tab[s]  = dlc_r;
      assign dat_tab[s]  = dat_r;
   end

   // control and flag registers: hardware events first, CPU write last
   always_comb begin
      en_n     = en_q;
      txreq_n  = txreq_q;
      rxfull_n = rxfull_q;
      txcmp_n  = txcmp_q;
      if (tx_busy && tx_done) begin
         txreq_n[tx_cur] = 1'b0;
         txcmp_n[tx_cur] = 1'b1;
      end
      if (rx_store) rxfull_n[rx_idx] = 1'b1;
      if (cpu_wr && a_glob) begin
         case (glob_reg_e'(g_sel))
            G_ENABLE: en_n     = wmerged[NSLOT-1:0];
            G_TXREQ:  txreq_n  = wmerged[NSLOT-1:0];
            G_RXFULL: rxfull_n = rxfull_n & ~wmerged[NSLOT-1:0];
            G_TXCMP:  txcmp_n  = txcmp_n & ~wmerged[NSLOT-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         txreq_q  <= '0;
         rxfull_q <= '0;
         txcmp_q  <= '0;
         lost_q   <= 1'b0;
      end else begin
         en_q     <= en_n;
         txreq_q  <= txreq_n;
         rxfull_q <= rxfull_n;
         txcmp_q  <= txcmp_n;
         lost_q   <= rx_valid & ~rx_any;
      end
   end

   // CPU stall with bounded wait
   logic [CNT_W-1:0] stall_cnt;
   logic             blk_busy;

   assign blk_busy  = rx_valid | tx_load;
   assign cpu_ready = ~blk_busy | (stall_cnt >= CNT_W'(STALL_MAX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    stall_cnt <= '0;
      else if (cpu_req && !cpu_ready) stall_cnt <= stall_cnt + CNT_W'(1);
      else                           stall_cnt <= '0;
   end

   // read mux
   always_comb begin
      cpu_rdata = '0;
      if (a_glob) begin
         case (glob_reg_e'(g_sel))
            G_ENABLE: cpu_rdata = WORD_W'(en_q);
            G_TXREQ:  cpu_rdata = WORD_W'(txreq_q);
            G_RXFULL: cpu_rdata = WORD_W'(rxfull_q);
            G_TXCMP:  cpu_rdata = WORD_W'(txcmp_q);
            default: ;
         endcase
      end else begin
         case (slot_off_e'(a_off))
            O_ID:   cpu_rdata = WORD_W'(id_tab[a_slot]);
            O_DLC:  cpu_rdata = WORD_W'(dlc_tab[a_slot]);
            O_MASK: cpu_rdata = WORD_W'(mask_tab[a_slot]);
            O_RSVD: cpu_rdata = '0;
            default: begin
               if (int'(a_word) < NWORDS)
                  cpu_rdata = dat_tab[a_slot][int'(a_word)*WORD_W +: WORD_W];
            end
         endcase
      end
   end

   assign rx_lost  = lost_q;
   assign rx_full  = rxfull_q;
   assign tx_valid = tx_busy;
   assign tx_slot  = tx_cur;
   assign tx_id    = tx_id_q;
   assign tx_dlc   = tx_dlc_q;
   assign tx_data  = tx_dat_q;
   assign tx_cmp   = txcmp_q;

   // checks next to the logic they guard
   assert_rx_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_store |-> (rx_cand[rx_idx] &&
                    ((rx_cand & ((NSLOT'(1) << rx_idx) - NSLOT'(1))) == '0)))
      else $error("receive frame not placed in lowest free matching slot");

   assert_rx_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_store |-> (en_q[rx_idx] && !rxfull_q[rx_idx]))
      else $error("frame stored in a disabled or full slot");

   assert_rx_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_store && !(cpu_wr && a_glob)) |=> rx_full[$past(rx_idx)])
      else $error("receive-full flag not set after store");

   assert_lost_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lost |-> $past(rx_valid))
      else $error("lost pulse without a received frame");

   assert_tx_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> (tx_elig[tx_pick] &&
                   ((tx_elig & ((NSLOT'(1) << tx_pick) - NSLOT'(1))) == '0)))
      else $error("transmit selection not lowest eligible slot");

   assert_stall_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall_cnt < CNT_W'(STALL_MAX))
      else $error("CPU stall exceeded its bound");

endmodule

// File: tb/sim_can_mbuf_sel.sv
module sim_can_mbuf_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [6:0]  cpu_addr = '0;
   logic [1:0]  cpu_be = 2'b11;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_ready;
   logic        rx_valid = 1'b0;
   logic [10:0] rx_id = '0;
   logic [3:0]  rx_dlc = '0;
   logic [63:0] rx_data = '0;
   logic        rx_lost;
   logic [7:0]  rx_full;
   logic        tx_valid;
   logic [2:0]  tx_slot;
   logic [10:0] tx_id;
   logic [3:0]  tx_dlc;
   logic [63:0] tx_data;
   logic        tx_done = 1'b0;
   logic [7:0]  tx_cmp;

   always #10 clk = ~clk;

   can_mbuf_sel u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .rx_valid(rx_valid), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
      .rx_lost(rx_lost), .rx_full(rx_full),
      .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_id(tx_id), .tx_dlc(tx_dlc),
      .tx_data(tx_data), .tx_done(tx_done), .tx_cmp(tx_cmp)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] sa(input int s, input int o);
      return 7'(s * 8 + o);
   endfunction
   function automatic logic [6:0] ga(input int g);
      return 7'(64 + g);
   endfunction

   task automatic cpu_acc(input logic we, input logic [6:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd, output int waited);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      #1;
      waited = 0;
      while (!cpu_ready) begin
         waited++;
         @(negedge clk);
         #1;
      end
      rd = cpu_rdata;
      @(posedge clk);
      #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      logic [15:0] rd; int w;
      cpu_acc(1'b1, a, d, 2'b11, rd, w);
   endtask

   task automatic wrb(input logic [6:0] a, input logic [15:0] d, input logic [1:0] be);
      logic [15:0] rd; int w;
      cpu_acc(1'b1, a, d, be, rd, w);
   endtask

   task automatic rdchk(input string tag, input logic [6:0] a, input logic [15:0] exp);
      logic [15:0] rd; int w;
      cpu_acc(1'b0, a, 16'h0, 2'b11, rd, w);
      chk(tag, 64'(rd), 64'(exp));
   endtask

   task automatic rx_send(input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_id = id; rx_dlc = dlc; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   // {id(12), expected rx_full(8), expected slot(4, F = lost), clear mask(8)}
   localparam logic [31:0] RXV [10] = '{
      {12'h100, 8'h01, 4'h0, 8'h01},
      {12'h2AB, 8'h02, 4'h1, 8'h02},
      {12'h200, 8'h02, 4'h1, 8'h00},
      {12'h200, 8'h06, 4'h2, 8'h06},
      {12'h053, 8'h08, 4'h3, 8'h00},
      {12'h05F, 8'h18, 4'h4, 8'h00},
      {12'h05A, 8'h38, 4'h5, 8'h00},
      {12'h051, 8'h38, 4'hF, 8'h38},
      {12'h300, 8'h20, 4'h5, 8'h20},
      {12'h7FF, 8'h20, 4'h5, 8'h20}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] rd;
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R11 reset state
      chk("R11 rx_full", 64'(rx_full), 64'h0);
      chk("R11 tx_valid", 64'(tx_valid), 64'h0);
      chk("R11 cpu_ready", 64'(cpu_ready), 64'h1);
      rdchk("R11 enable", ga(0), 16'h0000);
      rdchk("R11 slot3 mask", sa(3, 6), 16'h0000);

      // slot filters
      wr(sa(0, 0), 16'h100); wr(sa(0, 6), 16'h7FF);
      wr(sa(1, 0), 16'h200); wr(sa(1, 6), 16'h700);
      wr(sa(2, 0), 16'h200); wr(sa(2, 6), 16'h7FF);
      wr(sa(3, 0), 16'h050); wr(sa(3, 6), 16'h7F0);
      wr(sa(4, 0), 16'h050); wr(sa(4, 6), 16'h7F0);
      wr(sa(5, 0), 16'h000); wr(sa(5, 6), 16'h000);
      wr(sa(6, 0), 16'h300); wr(sa(6, 6), 16'h7FF);
      wr(ga(0), 16'h003F);
      rdchk("R1 slot1 mask", sa(1, 6), 16'h0700);
      rdchk("R1 slot6 id", sa(6, 0), 16'h0300);
      rdchk("R1 reserved word", sa(6, 7), 16'h0000);

      // vector walk: R4 masking, R5 lowest free match, R9 lost
      for (int v = 0; v < 10; v++) begin
         logic [10:0] vid;
         logic [7:0]  vfull, vclr;
         logic [3:0]  vslot;
         vid   = RXV[v][30:20];
         vfull = RXV[v][19:12];
         vslot = RXV[v][11:8];
         vclr  = RXV[v][7:0];
         rx_send(vid, 4'd3, 64'h0123_4567_89AB_CDEF ^ 64'(vid));
         #1;
         chk($sformatf("R9 lost vec%0d", v), 64'(rx_lost), 64'(vslot == 4'hF));
         chk($sformatf("R5 rx_full vec%0d", v), 64'(rx_full), 64'(vfull));
         rdchk($sformatf("R8 flag reg vec%0d", v), ga(2), 16'(vfull));
         if (vslot != 4'hF)
            rdchk($sformatf("R4 stored id vec%0d", v), sa(int'(vslot), 0), 16'(vid));
         if (vclr != 8'h00) wr(ga(2), 16'(vclr));
      end
      rdchk("R8 flags cleared", ga(2), 16'h0000);

      // R8 clamp and data layout
      rx_send(11'h100, 4'd12, 64'hF7E6_D5C4_B3A2_9180);
      rdchk("R8 dlc clamp", sa(0, 1), 16'h0008);
      rdchk("R8 data word0", sa(0, 2), 16'h9180);
      rdchk("R8 data word3", sa(0, 5), 16'hF7E6);
      wr(ga(2), 16'h0001);

      // R6 disabled slot ignored by filter
      wr(ga(0), 16'h001F);
      rx_send(11'h300, 4'd2, 64'h55);
      #1;
      chk("R6 disabled slot lost", 64'(rx_lost), 64'h1);
      rdchk("R6 disabled no flag", ga(2), 16'h0000);
      rdchk("R6 disabled id kept", sa(6, 0), 16'h0300);
      wr(ga(0), 16'h003F);

      // R6 / R7 disabled slot used as RAM with byte enables
      wr(sa(7, 3), 16'hABCD);
      rdchk("R6 ram word", sa(7, 3), 16'hABCD);
      wrb(sa(7, 3), 16'h1234, 2'b10);
      rdchk("R7 high byte ignored", sa(7, 3), 16'hABCD);
      wrb(sa(7, 3), 16'h1299, 2'b01);
      rdchk("R7 low byte zero high", sa(7, 3), 16'h0099);

      // R10 stall during receive
      @(negedge clk);
      rx_valid = 1'b1; rx_id = 11'h7FF;
      #1;
      chk("R10 ready low on rx", 64'(cpu_ready), 64'h0);
      @(negedge clk);
      rx_valid = 1'b0;
      #1;
      chk("R10 ready back", 64'(cpu_ready), 64'h1);
      wr(ga(2), 16'h00FF);

      // R2 / R3 transmit scheduling (slot6 disabled)
      wr(ga(1), 16'h0054);
      repeat (3) @(negedge clk);
      #1;
      chk("R2 tx_valid", 64'(tx_valid), 64'h1);
      chk("R2 tx_slot lowest", 64'(tx_slot), 64'h2);
      chk("R2 tx_id", 64'(tx_id), 64'h200);
      chk("R2 tx_dlc", 64'(tx_dlc), 64'h3);
      wr(ga(1), 16'h0055);
      repeat (2) @(negedge clk);
      #1;
      chk("R3 no preempt", 64'(tx_slot), 64'h2);
      pulse_done();
      repeat (3) @(negedge clk);
      #1;
      chk("R3 next is lowest", 64'(tx_slot), 64'h0);
      chk("R3 tx_cmp slot2", 64'(tx_cmp), 64'h04);
      rdchk("R3 req cleared", ga(1), 16'h0051);
      pulse_done();
      repeat (3) @(negedge clk);
      #1;
      chk("R2 then slot4", 64'(tx_slot), 64'h4);
      pulse_done();
      repeat (3) @(negedge clk);
      #1;
      chk("R6 disabled not sent", 64'(tx_valid), 64'h0);
      rdchk("R6 req left pending", ga(1), 16'h0040);
      rdchk("R3 cmp flags", ga(3), 16'h0015);
      wr(ga(3), 16'h0015);
      rdchk("R3 cmp w1c", ga(3), 16'h0000);

      // R10 stall bound under a long receive burst
      @(negedge clk);
      rx_valid = 1'b1; rx_id = 11'h051;
      fork
         begin
            repeat (70) @(negedge clk);
            rx_valid = 1'b0;
         end
      join_none
      cpu_acc(1'b0, ga(0), 16'h0, 2'b11, rd, w);
      chk("R10 stall bound", 64'(w), 64'd63);
      chk("R10 read during stall", 64'(rd), 64'h003F);
      repeat (75) @(negedge clk);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule